// File: doc/BRIEF.md
# Matrix Key Report Filter

This block sits between a keyboard matrix scanner and the keycode translation stage. Each cycle that it is idle it can accept one snapshot of up to eight key slots. Every slot carries a valid flag and a row/column pair. The block compacts the valid slots into a pressed-key list. It can drop a designated function-modifier key from that list and, while that key is held, move every other key into a second code bank. If ghost rejection is on, it throws away snapshots whose pattern could be produced by matrix ghosting.

An accepted snapshot is compared with the key set kept from the previous accepted snapshot. The block then sends a stream of events, one per handshake. Release events come first, one for each kept key that has gone. Press events follow, one for each key in the new set. A final sync beat closes the stream, and the new set becomes the kept set. A snapshot rejected as ghosted produces no events and leaves the kept set as it was.

Top module: `key_event_filter`

## Requirements
- R1: A slot occupies bits [8*i+7 : 8*i] of `snap_ent`: bit 7 is valid, bits 6:3 are the row and bits 2:0 are the column. The key code is row*8 + column. Slots with bit 7 clear contribute nothing.
- R2: Press events are issued in ascending slot order of the contributing slots.
- R3: With `fn_map_en` high, a valid slot whose 7-bit code equals `fn_code` produces no event, and every other press code is raised by 128 (rows times columns). With `fn_map_en` low, that slot is reported like any other key.
- R4: With `ghost_en` high and at least three keys counted (the function key excluded), the snapshot is discarded when some pair of keys shares a row and some pair shares a column. No events and no sync are produced, the kept set stays unchanged, and `snap_ready` stays high.
- R5: A snapshot is not discarded when `ghost_en` is low, when fewer than three keys are counted, or when only rows or only columns coincide.
- R6: For each kept key whose code is absent from the new set, a release event (`evt_press`=0) is issued, in kept order, before any press event.
- R7: Every key of the new set produces a press event (`evt_press`=1), including keys that were already kept.
- R8: Each accepted snapshot ends with one sync beat (`evt_sync`=1, `evt_code`=0). After that beat the new set is the kept set and `snap_ready` is high on the next cycle.
- R9: A snapshot with no contributing key releases every kept key, then gives only the sync beat, and leaves the kept set empty.
- R10: An event is transferred when `evt_valid` and `evt_ready` are both high. While it is stalled, its code and kind hold steady. `snap_ready` is low whenever an event stream is in progress.
- R11: After reset `snap_ready` is 1, `evt_valid` is 0 and the kept set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Block idle, snapshot taken this cycle |
| snap_ent | input | 64 | Eight packed key slots |
| fn_map_en | input | 1 | Enable function-key bank switching |
| ghost_en | input | 1 | Enable ghost rejection |
| fn_code | input | 7 | Row/column code of the function key |
| evt_valid | output | 1 | Event present |
| evt_ready | input | 1 | Consumer takes the event |
| evt_press | output | 1 | 1 press, 0 release |
| evt_sync | output | 1 | End-of-snapshot beat |
| evt_code | output | 8 | Key code of the event |

## Verification
A corrupted kept set does not show in the snapshot being handled. It shows in the next accepted snapshot, as a missing release, an extra release or a wrong release code. For this reason every scenario goes on to a following snapshot, and the bench keeps its own model of the kept set. An error in the slot walk or the event index shows within the same stream: an event is dropped or repeated before the sync beat, or the release and press phases are out of order. Backpressure runs expose an index that advances without a handshake.

// File: rtl/key_event_filter.sv
`timescale 1ns/1ps
module key_event_filter #(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int SLOTS = 8,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int KEY_W  = ROW_W + COL_W,
  localparam int ENT_W  = KEY_W + 1,
  localparam int CODE_W = KEY_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     snap_valid,
  output logic                     snap_ready,
  input  logic [SLOTS*ENT_W-1:0]   snap_ent,
  input  logic                     fn_map_en,
  input  logic                     ghost_en,
  input  logic [KEY_W-1:0]         fn_code,
  output logic                     evt_valid,
  input  logic                     evt_ready,
  output logic                     evt_press,
  output logic                     evt_sync,
  output logic [CODE_W-1:0]        evt_code
);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [CODE_W-1:0] BANK = CODE_W'(ROWS * COLS);

  typedef enum logic [1:0] {IDLE, REL, PRS, FIN} phase_t;

  phase_t             ph;
  logic [CODE_W-1:0]  held_c [SLOTS];
  logic [CNT_W-1:0]   held_n;
  logic [CODE_W-1:0]  nxt_c  [SLOTS];
  logic [CNT_W-1:0]   nxt_n;
  logic [CNT_W-1:0]   idx;

  logic [KEY_W-1:0]   raw   [SLOTS];
  logic [CODE_W-1:0]  cand  [SLOTS];
  logic [CNT_W-1:0]   raw_n;
  logic               fn_hit;
  logic               same_row, same_col, ghost;
  logic               in_new, rel_live, prs_live;
  logic [SLOT_W-1:0]  idx_s;

  always_comb begin
    raw_n  = '0;
    fn_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) raw[i] = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (snap_ent[i*ENT_W + KEY_W]) begin
        if (fn_map_en && snap_ent[i*ENT_W +: KEY_W] == fn_code) begin
          fn_hit = 1'b1;
        end else begin
          raw[raw_n[SLOT_W-1:0]] = snap_ent[i*ENT_W +: KEY_W];
          raw_n = raw_n + 1'b1;
        end
      end
    end
  end

  always_comb begin
    same_row = 1'b0;
    same_col = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = i + 1; j < SLOTS; j++) begin
        if (j < int'(raw_n)) begin
          if (raw[i][KEY_W-1:COL_W] == raw[j][KEY_W-1:COL_W]) same_row = 1'b1;
          if (raw[i][COL_W-1:0]     == raw[j][COL_W-1:0])     same_col = 1'b1;
        end
      end
    end
  end

  assign ghost = ghost_en && (raw_n >= CNT_W'(3)) && same_row && same_col;

  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      cand[i] = {1'b0, raw[i]} + (fn_hit ? BANK : '0);
  end

  assign idx_s = idx[SLOT_W-1:0];

  always_comb begin
    in_new = 1'b0;
    for (int k = 0; k < SLOTS; k++)
      if (k < int'(nxt_n) && nxt_c[k] == held_c[idx_s]) in_new = 1'b1;
  end

  assign rel_live   = idx < held_n;
  assign prs_live   = idx < nxt_n;
  assign snap_ready = (ph == IDLE);

  always_comb begin
    evt_valid = 1'b0;
    evt_press = 1'b0;
    evt_sync  = 1'b0;
    evt_code  = '0;
    case (ph)
      REL: begin
        evt_valid = rel_live && !in_new;
        evt_code  = held_c[idx_s];
      end
      PRS: begin
        evt_valid = prs_live;
        evt_press = 1'b1;
        evt_code  = nxt_c[idx_s];
      end
      FIN: begin
        evt_valid = 1'b1;
        evt_sync  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= IDLE;
      idx    <= '0;
      held_n <= '0;
      nxt_n  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        held_c[i] <= '0;
        nxt_c[i]  <= '0;
      end
    end else begin
      case (ph)
        IDLE: if (snap_valid && !ghost) begin
          for (int i = 0; i < SLOTS; i++) nxt_c[i] <= cand[i];
          nxt_n <= raw_n;
          idx   <= '0;
          ph    <= REL;
        end
        REL: begin
          if (!rel_live) begin
            idx <= '0;
            ph  <= PRS;
          end else if (in_new || evt_ready) begin
            idx <= idx + 1'b1;
          end
        end
        PRS: begin
          if (!prs_live) ph <= FIN;
          else if (evt_ready) idx <= idx + 1'b1;
        end
        FIN: if (evt_ready) begin
          for (int i = 0; i < SLOTS; i++) held_c[i] <= nxt_c[i];
          held_n <= nxt_n;
          ph     <= IDLE;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  // R10
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_code) && $stable(evt_press) && $stable(evt_sync));

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(snap_ready && evt_valid));

  // R4
  ghost_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid && snap_ready && ghost |=> snap_ready && !evt_valid);

  // R8
  sync_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready && evt_sync |=> snap_ready);

  // R8
  held_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_n <= CNT_W'(SLOTS));

  // R6
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_press |=> !(evt_valid && !evt_press && !evt_sync));
endmodule

// File: tb/key_event_filter_tb_top.sv
`timescale 1ns/1ps
module key_event_filter_tb_top;
  logic clk = 0, rst_n = 0;
  logic snap_valid = 0, fn_map_en = 0, ghost_en = 0, evt_ready = 0;
  logic [63:0] snap_ent = '0;
  logic [6:0]  fn_code = '0;
  logic snap_ready, evt_valid, evt_press, evt_sync;
  logic [7:0] evt_code;

  key_event_filter dut_i (
    .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_ent(snap_ent), .fn_map_en(fn_map_en), .ghost_en(ghost_en), .fn_code(fn_code),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_press(evt_press),
    .evt_sync(evt_sync), .evt_code(evt_code));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int bp = 0;
  int held [8];
  int held_n = 0;
  logic [9:0] got [40];
  logic [9:0] exp_e [40];
  int got_n, exp_n;
  bit exp_ghost;

  task automatic chk(string tag, bit ok, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] mk(int r, int c);
    return {1'b1, 4'(r), 3'(c)};
  endfunction

  task automatic model(logic [63:0] e);
    int nk [8];
    int nn = 0;
    bit fh = 0, sr = 0, sc = 0;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b = e[i*8 +: 8];
      if (b[7]) begin
        if (fn_map_en && b[6:0] == fn_code) fh = 1;
        else begin nk[nn] = int'(b[6:0]); nn++; end
      end
    end
    for (int i = 0; i < nn; i++)
      for (int j = i + 1; j < nn; j++) begin
        if ((nk[i] >> 3) == (nk[j] >> 3)) sr = 1;
        if ((nk[i] & 7) == (nk[j] & 7)) sc = 1;
      end
    exp_ghost = ghost_en && nn >= 3 && sr && sc;
    exp_n = 0;
    if (exp_ghost) return;
    for (int i = 0; i < nn; i++) if (fh) nk[i] += 128;
    for (int i = 0; i < held_n; i++) begin
      bit f = 0;
      for (int j = 0; j < nn; j++) if (nk[j] == held[i]) f = 1;
      if (!f) begin exp_e[exp_n] = {2'b00, 8'(held[i])}; exp_n++; end
    end
    for (int i = 0; i < nn; i++) begin exp_e[exp_n] = {2'b01, 8'(nk[i])}; exp_n++; end
    exp_e[exp_n] = 10'h200; exp_n++;
    for (int i = 0; i < nn; i++) held[i] = nk[i];
    held_n = nn;
  endtask

  task automatic send(logic [63:0] e);
    @(negedge clk);
    evt_ready = 0;
    chk("R10 snap_ready before offer", snap_ready === 1'b1, snap_ready, 1);
    snap_valid = 1; snap_ent = e;
    @(negedge clk);
    snap_valid = 0;
  endtask

  task automatic collect();
    got_n = 0;
    for (int c = 0; c < 400; c++) begin
      evt_ready = (bp != 0) ? (c % 3 != 1) : 1'b1;
      if (evt_valid && evt_ready) begin
        got[got_n] = {evt_sync, evt_press, evt_code};
        got_n++;
        if (evt_sync || got_n == 40) begin @(negedge clk); return; end
      end
      @(negedge clk);
    end
  endtask

  task automatic do_snap(string tag, logic [63:0] e);
    model(e);
    send(e);
    if (exp_ghost) begin
      bit seen = 0;
      for (int c = 0; c < 12; c++) begin
        evt_ready = 1;
        if (evt_valid) seen = 1;
        @(negedge clk);
      end
      chk({tag, " R4 no events"}, !seen, seen, 0);
      chk({tag, " R4 still idle"}, snap_ready === 1'b1, snap_ready, 1);
      got_n = 0;
    end else begin
      collect();
      chk({tag, " event count"}, got_n == exp_n, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
        chk({tag, " event"}, got[i] === exp_e[i], int'(got[i]), int'(exp_e[i]));
      chk({tag, " R8 idle after sync"}, snap_ready === 1'b1, snap_ready, 1);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 snap_ready", snap_ready === 1'b1, snap_ready, 1);
    chk("R11 evt_valid", evt_valid === 1'b0, evt_valid, 0);
  endtask

  task automatic t_single();
    do_snap("R1 single", {56'h0, mk(5, 3)});
    chk("R1 code 43", got[0] === 10'h12B, int'(got[0]), 10'h12B);
    chk("R8 sync beat", got[1] === 10'h200, int'(got[1]), 10'h200);
  endtask

  task automatic t_order();
    do_snap("R2 R7 order", {40'h0, mk(5, 3), 8'h35, mk(2, 1)});
    chk("R2 first press slot0", got[0] === 10'h111, int'(got[0]), 10'h111);
    chk("R7 held key repressed", got[1] === 10'h12B, int'(got[1]), 10'h12B);
  endtask

  task automatic t_release_bp();
    bp = 1;
    do_snap("R6 R10 release backpressure", {56'h0, mk(2, 1)});
    chk("R6 release first", got[0] === 10'h02B, int'(got[0]), 10'h02B);
    bp = 0;
  endtask

  task automatic t_fn();
    fn_map_en = 1; fn_code = 7'd0;
    do_snap("R3 fn bank", {48'h0, mk(1, 2), mk(0, 0)});
    chk("R3 offset code 138", got[1] === 10'h18A, int'(got[1]), 10'h18A);
    fn_map_en = 0;
    do_snap("R3 fn off", {48'h0, mk(1, 2), mk(0, 0)});
  endtask

  task automatic t_ghost();
    ghost_en = 1;
    do_snap("R4 ghost", {40'h0, mk(2, 1), mk(1, 2), mk(1, 1)});
    do_snap("R4 kept set intact", {56'h0, mk(7, 7)});
    do_snap("R5 row only", {40'h0, mk(1, 3), mk(1, 2), mk(1, 1)});
    do_snap("R5 distinct", {40'h0, mk(4, 6), mk(3, 5), mk(2, 4)});
    do_snap("R5 two keys", {48'h0, mk(3, 3), mk(3, 4)});
    ghost_en = 0;
    do_snap("R5 ghost off", {40'h0, mk(2, 1), mk(1, 2), mk(1, 1)});
  endtask

  task automatic t_full_empty();
    logic [63:0] e;
    for (int i = 0; i < 8; i++) e[i*8 +: 8] = mk(i + 8, 7 - i);
    do_snap("R1 full eight", e);
    do_snap("R1 invalid slots ignored", {8'h7F, 48'h0, 8'h55});
    do_snap("R9 empty", 64'h0);
    chk("R9 sync only", got_n == 1, got_n, 1);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_order();
    t_release_bp();
    t_fn();
    t_ghost();
    t_full_empty();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule